// File: doc/BRIEF.md
# Received Frame Filter and Unpacker

This block pulls received frames, one byte at a time, out of a radio's receive buffer through a byte-level SPI framer. Each frame is parsed in a fixed small layout. The first byte is a length. It is followed by a source address, a destination address, a four-byte payload and two check bytes. The radio computes the CRC itself and reports the result as one flag bit in the last check byte. This block only reads that flag.

A frame is accepted when three things hold: the CRC flag is set, the destination is not zero, and the destination equals the local address or the broadcast value 0xFF. An accepted frame becomes a 32-bit word plus its source address, offered on a start/ready output handshake. Every other frame is dropped without any trace. A frame with an unexpected but plausible length is drained byte by byte. A frame whose length cannot be valid causes the block to ask the framer to flush the whole receive buffer. In every case the block then resumes parsing, so stray traffic from neighbouring channels cannot lock it up.

Top module: `rxf_filter`

## Requirements
- R1: While reset is held and after it is released, `out_start`, `byte_req` and `flush_req` are low until a buffer byte arrives.
- R2: `byte_req` is high only while `fifo_has` is high, so an empty buffer is never read. The framer answers each request with a one-cycle `byte_ack` that carries `byte_in`.
- R3: A good frame is the length byte 8, then the source byte, then the destination byte, then payload bytes p0..p3, then two check bytes. It appears as `out_word` = {p0,p1,p2,p3}, most significant byte first, with `out_src` = source byte. `out_start` rises on the cycle after the last check byte is acknowledged.
- R4: A frame is accepted only when bit 7 of its second check byte is 1. The first check byte and the other bits of the second check byte are ignored.
- R5: The destination must equal `local_addr` or 0xFF. A destination of 0 is never accepted, whatever `local_addr` is.
- R6: While `out_start` is high and `out_ready` is low, `out_start`, `out_word` and `out_src` hold steady. A word transfers on a clock edge where both are high.
- R7: While a word is waiting on the output, no byte of the next frame is requested.
- R8: A length byte from 1 to MAX_LEN (127) other than 8 causes exactly that many further bytes to be read and discarded. Parsing then restarts at the next byte.
- R9: A length byte of 0 or above MAX_LEN raises `flush_req`. It stays high until `flush_ack`, no byte is requested meanwhile, and parsing then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| local_addr | input | 8 | Address of this node |
| fifo_has | input | 1 | Radio receive buffer holds at least one byte |
| byte_req | output | 1 | Request for the next buffer byte |
| byte_ack | input | 1 | One-cycle answer carrying a buffer byte |
| byte_in | input | 8 | Buffer byte, valid with `byte_ack` |
| flush_req | output | 1 | Request to empty the receive buffer |
| flush_ack | input | 1 | Flush completed |
| out_start | output | 1 | Accepted word is on the output |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Payload, first byte most significant |
| out_src | output | 8 | Source address of the accepted frame |

## Verification
The bench builds the block with its default parameters: four payload bytes and a length limit of 127. With these values every possible byte can be swept in each field that decides acceptance. All 256 destinations are tried against three local addresses, all 256 values of the final check byte are tried, and all 256 length bytes are tried. This reaches both drain and flush at every boundary, including 1, 7, 9, 127, 128 and 0. Separate scenarios hold the output back to observe the held word and the stalled buffer, and starve the buffer in mid-frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ADDR_BCAST = 8'hFF;
  localparam logic [BYTE_W-1:0] ADDR_NONE  = 8'h00;

  typedef enum logic [1:0] {
    S_LEN   = 2'd0,
    S_BODY  = 2'd1,
    S_DRAIN = 2'd2,
    S_FLUSH = 2'd3
  } rxf_state_t;
endpackage

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
  import rxf_pkg::*;
(
  input  logic [BYTE_W-1:0] dst,
  input  logic [BYTE_W-1:0] local_addr,
  input  logic              crc_ok,
  output logic              accept
);
  logic dst_hit;

  always_comb begin
    dst_hit = (dst == local_addr) || (dst == ADDR_BCAST);
    accept  = crc_ok && (dst != ADDR_NONE) && dst_hit;
  end
endmodule

// File: rtl/rxf_out_hold.sv
module rxf_out_hold
  import rxf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [BYTE_W-1:0] src_in,
  input  logic              ready,
  output logic              start,
  output logic [WORD_W-1:0] word,
  output logic [BYTE_W-1:0] src
);
  logic              full_n;
  logic              take;

  always_comb begin
    take   = start && ready;
    full_n = start;
    if (take) full_n = 1'b0;
    if (load) full_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start <= 1'b0;
    else        start <= full_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      src  <= '0;
    end else if (load) begin
      word <= word_in;
      src  <= src_in;
    end
  end

  // R6: offered word stays put until the consumer takes it
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    start && !ready |=> start && $stable(word) && $stable(src));
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter
  import rxf_pkg::*;
#(
  parameter int PAY_BYTES = 4,
  parameter int MAX_LEN   = 127
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               local_addr,
  input  logic                     fifo_has,
  output logic                     byte_req,
  input  logic                     byte_ack,
  input  logic [7:0]               byte_in,
  output logic                     flush_req,
  input  logic                     flush_ack,
  output logic                     out_start,
  input  logic                     out_ready,
  output logic [8*PAY_BYTES-1:0]   out_word,
  output logic [7:0]               out_src
);
  localparam int WORD_W = BYTE_W * PAY_BYTES;
  localparam logic [7:0] FRAME_L = 8'(2 + PAY_BYTES + 2);
  localparam logic [7:0] PAY_END = 8'(2 + PAY_BYTES);
  localparam logic [7:0] MAX_L   = 8'(MAX_LEN);

  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  rxf_state_t        st_q, st_n;
  logic [7:0]        rem_q, rem_n;
  logic [7:0]        src_q, src_n;
  logic [7:0]        dst_q, dst_n;
  logic [WORD_W-1:0] pay_q, pay_n;
  logic [7:0]        idx;
  logic              accept;
  logic              load;
  logic              fetching;

  rxf_addr_match u_match (
    .dst        (dst_q),
    .local_addr (local_addr),
    .crc_ok     (byte_in[7]),
    .accept     (accept)
  );

  always_comb begin
    fetching  = (st_q != S_FLUSH) && !(st_q == S_LEN && out_start);
    byte_req  = fetching && fifo_has;
    flush_req = (st_q == S_FLUSH);
    idx       = FRAME_L - rem_q;
  end

  always_comb begin
    st_n  = st_q;
    rem_n = rem_q;
    src_n = src_q;
    dst_n = dst_q;
    pay_n = pay_q;
    load  = 1'b0;
    unique case (st_q)
      S_LEN: if (byte_ack) begin
        if (byte_in == 8'd0 || byte_in > MAX_L) begin
          st_n = S_FLUSH;
        end else if (byte_in == FRAME_L) begin
          st_n  = S_BODY;
          rem_n = FRAME_L;
        end else begin
          st_n  = S_DRAIN;
          rem_n = byte_in;
        end
      end
      S_BODY: if (byte_ack) begin
        rem_n = rem_q - 8'd1;
        if (idx == 8'd0) src_n = byte_in;
        if (idx == 8'd1) dst_n = byte_in;
        if (idx >= 8'd2 && idx < PAY_END)
          pay_n = {pay_q[WORD_W-BYTE_W-1:0], byte_in};
        if (rem_q == 8'd1) begin
          load = accept;
          st_n = S_LEN;
        end
      end
      S_DRAIN: if (byte_ack) begin
        rem_n = rem_q - 8'd1;
        if (rem_q == 8'd1) st_n = S_LEN;
      end
      S_FLUSH: if (flush_ack) st_n = S_LEN;
      default: st_n = S_LEN;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q  <= S_LEN;
      rem_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      pay_q <= '0;
    end else begin
      st_q  <= st_n;
      rem_q <= rem_n;
      src_q <= src_n;
      dst_q <= dst_n;
      pay_q <= pay_n;
    end
  end

  rxf_out_hold #(.WORD_W(WORD_W)) u_out (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (load),
    .word_in (pay_n),
    .src_in  (src_q),
    .ready   (out_ready),
    .start   (out_start),
    .word    (out_word),
    .src     (out_src)
  );

  // R2: never ask for a byte the buffer does not hold
  a_r2_no_empty_read: assert property (@(posedge clk) disable iff (!srst_n)
    byte_req |-> fifo_has);
  // R3: a new word only follows a byte delivered on the previous edge
  a_r3_word_after_byte: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(out_start) |-> $past(byte_ack));
  // R9: flush request held until acknowledged, and no reads meanwhile
  a_r9_flush_held: assert property (@(posedge clk) disable iff (!srst_n)
    flush_req && !flush_ack |=> flush_req);
  a_r9_no_read_in_flush: assert property (@(posedge clk) disable iff (!srst_n)
    flush_req |-> !byte_req);
endmodule

// File: tb/sim_rxf_filter.sv
module sim_rxf_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  local_addr = 8'h35;
  logic        fifo_has;
  logic        byte_req;
  logic        byte_ack = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        flush_req;
  logic        flush_ack = 1'b0;
  logic        out_start;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic [7:0]  out_src;

  always #10 clk = ~clk;

  rxf_filter u0 (
    .clk(clk), .rst_n(rst_n), .local_addr(local_addr), .fifo_has(fifo_has),
    .byte_req(byte_req), .byte_ack(byte_ack), .byte_in(byte_in),
    .flush_req(flush_req), .flush_ack(flush_ack), .out_start(out_start),
    .out_ready(out_ready), .out_word(out_word), .out_src(out_src)
  );

  logic [7:0]  q [0:1023];
  int          rd = 0, wr = 0;
  int          bad_read = 0, nflush = 0, nrx = 0;
  logic [31:0] rx_word [0:7];
  logic [7:0]  rx_src [0:7];
  int          total = 0, bad = 0;

  assign fifo_has = (rd < wr);

  // framer and consumer model, acting on the falling edge
  always @(negedge clk) begin
    byte_ack  = 1'b0;
    flush_ack = 1'b0;
    if (rst_n) begin
      if (byte_req) begin
        if (rd >= wr) bad_read++;
        else begin
          byte_in  = q[rd];
          rd++;
          byte_ack = 1'b1;
        end
      end
      if (flush_req) begin
        rd = wr;
        flush_ack = 1'b1;
        nflush++;
      end
      if (out_start && out_ready) begin
        if (nrx < 8) begin
          rx_word[nrx] = out_word;
          rx_src[nrx]  = out_src;
        end
        nrx++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    q[wr] = b;
    wr++;
  endtask

  task automatic push_frame(input logic [7:0] s, input logic [7:0] d, input logic [31:0] w, input logic [7:0] fcs1);
    push(8'd8); push(s); push(d);
    push(w[31:24]); push(w[23:16]); push(w[15:8]); push(w[7:0]);
    push(8'h2A); push(fcs1);
  endtask

  task automatic fresh();
    @(posedge clk); #1;
    rd = 0; wr = 0; nrx = 0;
  endtask

  task automatic settle();
    while (rd != wr) @(posedge clk);
    repeat (8) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fl0;
    logic [7:0] locs [3];
    locs[0] = 8'h01; locs[1] = 8'h35; locs[2] = 8'hFE;

    repeat (4) @(negedge clk);
    check(!out_start && !byte_req && !flush_req, "R1 reset outputs", {29'd0, out_start, byte_req, flush_req}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!out_start && !byte_req && !flush_req, "R1 after release", {29'd0, out_start, byte_req, flush_req}, 0);

    // R5 / R3: every destination against three local addresses
    foreach (locs[li]) begin
      local_addr = locs[li];
      for (int d = 0; d < 256; d++) begin
        logic [31:0] w;
        bit exp;
        w = {8'(d), ~8'(d), 8'(d + 1), 8'hC3};
        exp = (d != 0) && (8'(d) == locs[li] || d == 255);
        fresh();
        push_frame(8'(d) ^ 8'h5A, 8'(d), w, 8'h80);
        settle();
        check(nrx == (exp ? 1 : 0), "R5 dest match", nrx, exp);
        if (exp && nrx == 1) begin
          check(rx_word[0] == w, "R3 payload order", rx_word[0], w);
          check(rx_src[0] == (8'(d) ^ 8'h5A), "R3 source", rx_src[0], 8'(d) ^ 8'h5A);
        end
      end
    end

    // R4: every value of the flag-carrying check byte
    local_addr = 8'h35;
    for (int c = 0; c < 256; c++) begin
      fresh();
      push_frame(8'h11, 8'h35, 32'hA5A5_0000 | 32'(c), 8'(c));
      settle();
      check(nrx == (c >= 128 ? 1 : 0), "R4 crc flag", nrx, c >= 128);
    end

    // R8 / R9: every length byte
    for (int L = 0; L < 256; L++) begin
      if (L == 8) continue;
      fresh();
      fl0 = nflush;
      push(8'(L));
      if (L >= 1 && L <= 127) begin
        for (int i = 0; i < L; i++) push(8'(i * 7));
        push_frame(8'h22, 8'hFF, 32'(L) * 32'h01010101, 8'hFF);
        settle();
        check(nrx == 1 && rx_word[0] == 32'(L) * 32'h01010101, "R8 drain by length", nrx, 1);
        check(nflush == fl0, "R8 no flush", nflush - fl0, 0);
      end else begin
        push(8'h08); push(8'h01);
        settle();
        check(nflush == fl0 + 1, "R9 flush issued", nflush - fl0, 1);
        check(nrx == 0, "R9 flushed bytes dropped", nrx, 0);
        push_frame(8'h23, 8'h35, 32'hF00D_0000 | 32'(L), 8'h80);
        settle();
        check(nrx == 1 && rx_word[0] == (32'hF00D_0000 | 32'(L)), "R9 resume", nrx, 1);
      end
    end

    // R6 / R7: consumer stalls with two frames waiting
    fresh();
    out_ready = 1'b0;
    push_frame(8'h41, 8'h35, 32'h1234_5678, 8'h80);
    push_frame(8'h42, 8'h35, 32'h9ABC_DEF0, 8'h80);
    repeat (60) @(posedge clk); #1;
    check(out_start && out_word == 32'h1234_5678, "R6 word held", out_word, 32'h1234_5678);
    check(rd == 9, "R7 next frame not read", rd, 9);
    repeat (30) @(posedge clk); #1;
    check(out_start && out_word == 32'h1234_5678 && out_src == 8'h41, "R6 still held", out_word, 32'h1234_5678);
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    check(nrx == 1 && rx_word[0] == 32'h1234_5678, "R6 single transfer", nrx, 1);
    repeat (60) @(posedge clk); #1;
    check(out_start && out_word == 32'h9ABC_DEF0 && out_src == 8'h42, "R6 second word", out_word, 32'h9ABC_DEF0);
    out_ready = 1'b1;
    settle();
    check(nrx == 2, "R6 both consumed", nrx, 2);

    // R2: buffer starves in mid-frame
    fresh();
    push(8'd8); push(8'h55); push(8'h35); push(8'hDE);
    repeat (40) @(posedge clk); #1;
    check(!out_start, "R2 waits on empty", out_start, 0);
    push(8'hAD); push(8'hBE); push(8'hEF); push(8'h00); push(8'h80);
    settle();
    check(nrx == 1 && rx_word[0] == 32'hDEAD_BEEF, "R2 resumes frame", rx_word[0], 32'hDEAD_BEEF);
    check(bad_read == 0, "R2 no empty read", bad_read, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule